// File: doc/BRIEF.md
# Voltage Setpoint to DAC Code Converter

This block turns a requested output voltage, expressed as a whole number of tenths of a volt between 0.0 V and 10.0 V, into the drive word for an 8-bit digital-to-analog converter, plus a half-step line that adds half of one code step and so works as a ninth, least-significant bit. The converter is scaled so that 10.0 V lands on code 250 rather than 255. One code step is then exactly 40 mV, and every tenth of a volt falls either on a whole code or exactly halfway between two codes.

The conversion uses no divider. Five times the setpoint is formed with a shift and an add. Its upper bits give the code and the setpoint's lowest bit gives the half-step. A setpoint above the full-scale value is pinned to full scale and flagged. Setpoints enter through a valid/ready handshake. The result leaves through a single register stage, one cycle after acceptance, and holds while the consumer stalls.

Top module: `dacsp_conv`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0 and out_code, out_half and out_over are all 0.
- R2: A setpoint of 0 yields out_code 0 with out_half 0 and out_over 0.
- R3: A setpoint of 100 (10.0 V) yields out_code 250 with out_half 0, and no accepted setpoint ever produces a code above 250.
- R4: An even in-range setpoint t yields out_code = t*5/2 exactly, with out_half 0 (for example 52 gives 130).
- R5: An odd in-range setpoint t yields out_code = floor(t*5/2), with out_half 1 (for example 53 gives 132 plus the half-step).
- R6: A setpoint above 100 yields out_code 250, out_half 0 and out_over 1.
- R7: Every setpoint from 0 to 100 yields out_over 0.
- R8: A setpoint accepted at a clock edge (in_valid and in_ready both high) appears on the outputs with out_valid high immediately after that edge.
- R9: While out_valid is high and out_ready is low, in_ready is low, and out_code, out_half and out_over hold their values whatever is offered at the input.
- R10: in_ready is high whenever out_valid is low or out_ready is high. If a result is taken and no new setpoint is accepted at the same edge, out_valid falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A setpoint is offered |
| in_ready | output | 1 | The block can take a setpoint this cycle |
| in_tenths | input | IN_W (8) | Setpoint in tenths of a volt |
| out_valid | output | 1 | A converted result is held on the outputs |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_code | output | 8 | DAC code, 40 mV per step |
| out_half | output | 1 | Half-step line, adds 20 mV |
| out_over | output | 1 | Setpoint exceeded full scale and was clamped |

## Verification
The bench builds the block with its defaults: an 8-bit setpoint and full scale at 100 tenths. With those values the whole input space of 256 setpoints is small enough to sweep. Every legal setpoint and every out-of-range code up to 255 goes through the converter, while the output stalls on a fixed pattern. A second back-to-back pass runs with the consumer always ready, and directed stalls confirm that the held result survives a competing input.

// File: rtl/dacsp_pkg.sv
package dacsp_pkg;
  parameter int unsigned DAC_BITS = 8;

  typedef logic [DAC_BITS-1:0] dac_code_t;

  typedef struct packed {
    logic      over;
    logic      half;
    dac_code_t code;
  } dac_word_t;
endpackage

// File: rtl/dacsp_scale.sv
module dacsp_scale
  import dacsp_pkg::*;
#(
  parameter int unsigned IN_W        = 8,
  parameter int unsigned FULL_TENTHS = 100
) (
  input  logic [IN_W-1:0] tenths,
  output dac_word_t       word
);
  localparam int unsigned PROD_W    = IN_W + 3;
  localparam int unsigned FULL_CODE = (FULL_TENTHS * 5) / 2;

  logic [PROD_W-1:0] wide_in;
  logic [PROD_W-1:0] times5;
  logic [PROD_W-1:0] halved;
  logic              above;

  // five times the setpoint: x + 4x, no multiplier
  assign wide_in = PROD_W'(tenths);
  assign times5  = wide_in + (wide_in << 2);
  assign halved  = times5 >> 1;
  assign above   = wide_in > PROD_W'(FULL_TENTHS);

  always_comb begin
    word.over = above;
    if (above) begin
      word.code = DAC_BITS'(FULL_CODE);
      word.half = 1'b0;
    end else begin
      word.code = DAC_BITS'(halved);
      word.half = tenths[0];
    end
  end

  // R6: a clamped result never carries the half-step
  always_comb begin
    a_r6_clamp_no_half: assert (!(word.over && word.half));
  end
endmodule

// File: rtl/dacsp_stage.sv
module dacsp_stage
  import dacsp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      in_valid,
  output logic      in_ready,
  input  dac_word_t in_word,
  output logic      out_valid,
  input  logic      out_ready,
  output dac_word_t out_word
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_word  <= in_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: reset leaves the stage empty and cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_word == '0));

  // R8: an accepted setpoint is visible after one edge
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R9: a stalled result holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R10: a consumed result with nothing new behind it drains
  a_r10_drain: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/dacsp_conv.sv
module dacsp_conv
  import dacsp_pkg::*;
#(
  parameter int unsigned IN_W        = 8,
  parameter int unsigned FULL_TENTHS = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [IN_W-1:0]     in_tenths,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DAC_BITS-1:0] out_code,
  output logic                out_half,
  output logic                out_over
);
  localparam int unsigned FULL_CODE = (FULL_TENTHS * 5) / 2;

  dac_word_t next_word;
  dac_word_t held_word;

  dacsp_scale #(
    .IN_W        (IN_W),
    .FULL_TENTHS (FULL_TENTHS)
  ) u_scale (
    .tenths (in_tenths),
    .word   (next_word)
  );

  dacsp_stage u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (next_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (held_word)
  );

  assign out_code = held_word.code;
  assign out_half = held_word.half;
  assign out_over = held_word.over;

  // R3: the held code never exceeds full scale
  a_r3_code_limit: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (32'(out_code) <= FULL_CODE));

  // R6: a flagged result sits exactly at full scale
  a_r6_clamp_value: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_over) |-> (32'(out_code) == FULL_CODE && !out_half));
endmodule

// File: tb/sim_dacsp_conv.sv
`timescale 1ns/1ps
module sim_dacsp_conv;
  typedef struct {
    int t;
    int code;
    int half;
    int over;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_tenths = '0;
  logic       out_ready = 1'b0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_code;
  logic       out_half;
  logic       out_over;

  int   checks = 0;
  int   errors = 0;
  bit   bp_on  = 1'b0;
  bit   done   = 1'b0;
  int   cyc    = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  dacsp_conv u0 (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_tenths (in_tenths),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code),
    .out_half  (out_half),
    .out_over  (out_over)
  );

  function automatic exp_t model(int t);
    exp_t e;
    e.t = t;
    if (t > 100) begin
      e.code = 250; e.half = 0; e.over = 1;
    end else begin
      e.code = (t * 5) / 2; e.half = t % 2; e.over = 0;
    end
    return e;
  endfunction

  function automatic string tag_of(int t);
    if (t == 0)   return "R2";
    if (t == 100) return "R3";
    if (t > 100)  return "R6";
    if (t % 2)    return "R5/R7";
    return "R4/R7";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // driver: called just after a falling edge, returns after the accepting edge
  task automatic send(int t);
    in_valid  = 1'b1;
    in_tenths = 8'(t);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    sb.push_back(model(t));
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (bp_on) out_ready = ((cyc % 5) != 3);
  end

  // monitor: a transfer happens at the next rising edge
  always @(negedge clk) begin
    #2;
    if (!rst && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        string r;
        e = sb.pop_front();
        r = tag_of(e.t);
        check(int'(out_code) == e.code && int'(out_half) == e.half &&
              int'(out_over) == e.over, r, $sformatf("t=%0d code", e.t),
              int'(out_code) * 4 + int'(out_half) * 2 + int'(out_over),
              e.code * 4 + e.half * 2 + e.over);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    #1;
    // R1: cleared during reset
    check(!out_valid && out_code == 0 && !out_half && !out_over, "R1",
          "reset state", int'(out_valid) + int'(out_code), 0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(!out_valid && out_code == 0, "R1", "after reset",
          int'(out_valid) + int'(out_code), 0);
    check(in_ready == 1'b1, "R10", "ready when empty", int'(in_ready), 1);

    // R8: latency with the consumer ready
    out_ready = 1'b1;
    send(10);
    #1;
    check(out_valid && out_code == 25, "R8", "one-cycle result", int'(out_code), 25);
    in_valid = 1'b0;
    @(negedge clk);
    #1;
    check(!out_valid, "R10", "drain without new input", int'(out_valid), 0);

    // R9: stall holds the result against a competing setpoint
    out_ready = 1'b0;
    send(53);
    #1;
    check(out_valid && out_code == 132 && out_half, "R5", "53 directed",
          int'(out_code) * 2 + int'(out_half), 265);
    in_tenths = 8'd200;
    for (int k = 0; k < 4; k++) begin
      check(!in_ready, "R9", "ready low while stalled", int'(in_ready), 0);
      check(out_code == 132 && out_half && !out_over, "R9", "held code",
            int'(out_code), 132);
      @(negedge clk);
      #1;
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    check(!out_valid, "R10", "drain after stall", int'(out_valid), 0);

    // full sweep under a stall pattern
    bp_on = 1'b1;
    for (int t = 0; t < 256; t++) send(t);
    in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    bp_on = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);

    // back-to-back pass, consumer always ready
    for (int t = 0; t <= 120; t++) send(t);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    #3;
    check(sb.size() == 0, "R8", "scoreboard drained", sb.size(), 0);
    check(!out_valid, "R10", "idle at end", int'(out_valid), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule